// File: doc/BRIEF.md
# Prioritized Reset Cause Capture Register

This block sits in the reset controller of a chip. Every source that can force a reset raises one bit of a request vector. The bit index is the 5-bit code of that cause. When several bits rise together, the block keeps the smallest legal code, because a smaller code means a deeper reset. It holds that code in a sticky register until software reads it. Reading returns the code and clears the register in the same access.

Each captured cause is also sorted into a reset level. The block drives a set of nested domain reset outputs for the domains that the level reaches. These outputs are held for a programmable number of cycles. They are then released one domain per cycle, starting with the deepest domain and ending with the CPU.

Top module: `rst_cause_capture`

## Requirements
- R1: After reset the held code is 0x00 and every domain output is low. A read with nothing captured returns code 0 and level 0.
- R2: A read returns the held code on `rd_data_o` in the same cycle and clears the register. A second read with no new cause in between returns 0.
- R3: When several legal request bits are high in one cycle, the code captured is the smallest set index.
- R4: Request bit 0 and the reserved indices are ignored. These are 6, 7, 10, 11, 15, 18, 19, 22 to 25, 30 and 31. They are never recorded and raise no domain output.
- R5: When no read occurs, a new cause replaces the held one only if its code is smaller. The register keeps the deepest cause seen since the last read.
- R6: A read and a capture in the same cycle behave as follows. The read returns the old code, and the register then holds the new cause.
- R7: `rd_level_o` gives the level of the code being read. The encoding is 0 none, 1 power-on (codes 1 to 3), 2 brown-out (4 to 5), 3 boot (8 to 14), 4 system (16 to 27) and 5 CPU (28, 29).
- R8: The domain bits are 0 CPU, 1 peripherals, 2 boot configuration, 3 supply-level state and 4 retention state. A captured code c asserts bit d when c is below that bit's limit. The limits are 32, 28, 16, 8 and 4 for bits 0 to 4.
- R9: The domains raised by a capture stay high for HOLD_CYC+1 cycles. After that, one bit is released per cycle, highest index first, so the CPU is released last.
- R10: A capture during a running sequence ORs its domains into the active set and restarts the hold period.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low power-up clear |
| req_i | input | 32 | Reset requests, bit index = cause code |
| rd_en_i | input | 1 | Read strobe; clears the register |
| rd_data_o | output | 5 | Held code during a read, else 0 |
| rd_level_o | output | 3 | Level of the code being read, else 0 |
| dom_rst_o | output | 5 | Per-domain reset enables |

## Verification
A request sampled at one clock edge shows up in `dom_rst_o` just after that edge. The scoreboard queues one expected domain vector for each following cycle: HOLD_CYC+1 copies of the full set, then one vector per release. The monitor pops one entry per cycle at the falling edge. Read data is combinational, so the bench checks it at the falling edge that raises the strobe. It then checks that a second read one cycle later sees the cleared register. For R6, the bench checks the returned old code in the same cycle and reads the new code only after the domain sequence has drained.

// File: rtl/rcc_pkg.sv
package rcc_pkg;

   localparam int CODE_W = 5;
   localparam int NCAUSE = 1 << CODE_W;
   localparam int NDOM   = 5;

   typedef enum logic [2:0] {
      LVL_NONE = 3'd0,
      LVL_POR  = 3'd1,
      LVL_BOR  = 3'd2,
      LVL_BOOT = 3'd3,
      LVL_SYS  = 3'd4,
      LVL_CPU  = 3'd5
   } lvl_e;

   function automatic logic cause_legal(input logic [CODE_W-1:0] c);
      case (c)
         5'd1, 5'd2, 5'd3, 5'd4, 5'd5,
         5'd8, 5'd9, 5'd12, 5'd13, 5'd14,
         5'd16, 5'd17, 5'd20, 5'd21, 5'd26, 5'd27,
         5'd28, 5'd29: cause_legal = 1'b1;
         default:      cause_legal = 1'b0;
      endcase
   endfunction

   function automatic logic [NCAUSE-1:0] legal_vec();
      logic [NCAUSE-1:0] v;
      for (int i = 0; i < NCAUSE; i++) v[i] = cause_legal(CODE_W'(i));
      return v;
   endfunction

   function automatic lvl_e cause_level(input logic [CODE_W-1:0] c);
      if (c == '0)        return LVL_NONE;
      else if (c < 5'd4)  return LVL_POR;
      else if (c < 5'd8)  return LVL_BOR;
      else if (c < 5'd16) return LVL_BOOT;
      else if (c < 5'd28) return LVL_SYS;
      else                return LVL_CPU;
   endfunction

   // domain d is hit by codes strictly below its limit
   function automatic logic [CODE_W:0] dom_limit(input int d);
      case (d)
         0:       dom_limit = 6'd32;
         1:       dom_limit = 6'd28;
         2:       dom_limit = 6'd16;
         3:       dom_limit = 6'd8;
         default: dom_limit = 6'd4;
      endcase
   endfunction

endpackage

// File: rtl/rcc_prio_arb.sv
module rcc_prio_arb
   import rcc_pkg::*;
#(
   parameter int N   = NCAUSE,
   parameter int IDX_W = $clog2(N)
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic [N-1:0]     req,
   input  logic [N-1:0]     legal,
   output logic             win_vld,
   output logic [IDX_W-1:0] win_idx
);

   logic [N-1:0] qual;

   genvar g;
   generate
      for (g = 0; g < N; g++) begin : g_qual
         assign qual[g] = req[g] & legal[g];
      end
   endgenerate

   always_comb begin
      win_vld = 1'b0;
      win_idx = '0;
      for (int i = N - 1; i >= 0; i--) begin
         if (qual[i]) begin
            win_vld = 1'b1;
            win_idx = IDX_W'(i);
         end
      end
   end

   logic [N-1:0] below_win;
   assign below_win = (N'(1) << win_idx) - N'(1);

   // R3: the winner is a qualified request with no qualified request below it
   a_r3_lowest_wins: assert property (@(posedge clk) disable iff (!rst_n)
      win_vld |-> (qual[win_idx] && ((qual & below_win) == '0)));

   a_r4_silent_when_none: assert property (@(posedge clk) disable iff (!rst_n)
      (qual == '0) |-> !win_vld);

endmodule

// File: rtl/rcc_cause_reg.sv
module rcc_cause_reg
   import rcc_pkg::*;
#(
   parameter int W = CODE_W,
   parameter logic [(1<<W)-1:0] LEGAL = '1
) (
   input  logic         clk,
   input  logic         rst_n,
   input  logic         win_vld,
   input  logic [W-1:0] win_code,
   input  logic         rd_en,
   output logic [W-1:0] code_q
);

   logic take_new;

   always_comb begin
      take_new = 1'b0;
      if (win_vld) begin
         if (rd_en || code_q == '0 || win_code < code_q) take_new = 1'b1;
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)        code_q <= '0;
      else if (take_new) code_q <= win_code;
      else if (rd_en)    code_q <= '0;
   end

   a_r2_clear_on_read: assert property (@(posedge clk) disable iff (!rst_n)
      (rd_en && !win_vld) |=> (code_q == '0));

   a_r6_capture_beats_read: assert property (@(posedge clk) disable iff (!rst_n)
      (rd_en && win_vld) |=> (code_q == $past(win_code)));

   a_r5_keep_deepest: assert property (@(posedge clk) disable iff (!rst_n)
      (!rd_en && code_q != '0) |=> (code_q != '0 && code_q <= $past(code_q)));

   a_r4_only_legal: assert property (@(posedge clk) disable iff (!rst_n)
      (code_q == '0) || LEGAL[code_q]);

endmodule

// File: rtl/rcc_dom_seq.sv
module rcc_dom_seq #(
   parameter int ND       = 5,
   parameter int HOLD_CYC = 16,
   parameter int CNT_W    = $clog2(HOLD_CYC + 1)
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          cap_vld,
   input  logic [ND-1:0] cap_mask,
   output logic [ND-1:0] dom_q
);

   logic [CNT_W-1:0] cnt_q;
   logic [ND-1:0]    top_bit;

   always_comb begin
      top_bit = '0;
      for (int i = 0; i < ND; i++) begin
         if (dom_q[i]) top_bit = ND'(1) << i;
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         dom_q <= '0;
         cnt_q <= '0;
      end else if (cap_vld) begin
         dom_q <= dom_q | cap_mask;
         cnt_q <= CNT_W'(HOLD_CYC);
      end else if (cnt_q != '0) begin
         cnt_q <= cnt_q - CNT_W'(1);
      end else if (dom_q != '0) begin
         dom_q <= dom_q & ~top_bit;
      end
   end

   // R8: a higher domain is never active without every lower one
   a_r8_nested: assert property (@(posedge clk) disable iff (!rst_n)
      ((dom_q >> 1) & ~dom_q) == '0);

   // R9: at most one domain released per cycle
   a_r9_one_release: assert property (@(posedge clk) disable iff (!rst_n)
      (!cap_vld && dom_q != '0) |=> ($countones(dom_q) + 1 >= $countones($past(dom_q))));

   a_r10_capture_covers: assert property (@(posedge clk) disable iff (!rst_n)
      cap_vld |=> ((dom_q & $past(cap_mask)) == $past(cap_mask)));

endmodule

// File: rtl/rst_cause_capture.sv
module rst_cause_capture
   import rcc_pkg::*;
#(
   parameter int CAUSE_W  = 5,
   parameter int HOLD_CYC = 16,
   localparam int NREQ    = 1 << CAUSE_W
) (
   input  logic               clk,
   input  logic               rst_n,
   input  logic [NREQ-1:0]    req_i,
   input  logic               rd_en_i,
   output logic [CAUSE_W-1:0] rd_data_o,
   output logic [2:0]         rd_level_o,
   output logic [NDOM-1:0]    dom_rst_o
);

   generate
      if (CAUSE_W != CODE_W) begin : g_bad_width
         $error("rst_cause_capture: CAUSE_W must equal the fixed code width");
      end
      if (HOLD_CYC < 1) begin : g_bad_hold
         $error("rst_cause_capture: HOLD_CYC must be at least 1");
      end
   endgenerate

   localparam logic [NREQ-1:0] LEGAL = legal_vec();

   logic               win_vld;
   logic [CAUSE_W-1:0] win_code;
   logic [CAUSE_W-1:0] code_q;
   logic [NDOM-1:0]    cap_mask;

   rcc_prio_arb #(.N(NREQ), .IDX_W(CAUSE_W)) u_arb (
      .clk     (clk),
      .rst_n   (rst_n),
      .req     (req_i),
      .legal   (LEGAL),
      .win_vld (win_vld),
      .win_idx (win_code)
   );

   rcc_cause_reg #(.W(CAUSE_W), .LEGAL(LEGAL)) u_reg (
      .clk      (clk),
      .rst_n    (rst_n),
      .win_vld  (win_vld),
      .win_code (win_code),
      .rd_en    (rd_en_i),
      .code_q   (code_q)
   );

   genvar d;
   generate
      for (d = 0; d < NDOM; d++) begin : g_dmask
         assign cap_mask[d] = ({1'b0, win_code} < dom_limit(d));
      end
   endgenerate

   rcc_dom_seq #(.ND(NDOM), .HOLD_CYC(HOLD_CYC)) u_seq (
      .clk      (clk),
      .rst_n    (rst_n),
      .cap_vld  (win_vld),
      .cap_mask (cap_mask),
      .dom_q    (dom_rst_o)
   );

   assign rd_data_o  = rd_en_i ? code_q : '0;
   assign rd_level_o = rd_en_i ? 3'(cause_level(code_q)) : 3'(LVL_NONE);

   a_r7_level_with_code: assert property (@(posedge clk) disable iff (!rst_n)
      rd_en_i |-> ((rd_data_o == '0) == (rd_level_o == 3'd0)));

   a_r9_cpu_last: assert property (@(posedge clk) disable iff (!rst_n)
      !dom_rst_o[0] |-> (dom_rst_o == '0));

endmodule

// File: tb/tb_rst_cause_capture.sv
module tb_rst_cause_capture;

   localparam int CLK_PERIOD = 10;
   localparam int HOLD = 3;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic [31:0] req_i = '0;
   logic        rd_en_i = 1'b0;
   logic [4:0]  rd_data_o;
   logic [2:0]  rd_level_o;
   logic [4:0]  dom_rst_o;

   int n_chk = 0;
   int n_bad = 0;

   typedef struct {
      logic [4:0] mask;
      string      tag;
   } exp_t;

   exp_t exp_q[$];

   always #(CLK_PERIOD/2) clk = ~clk;

   rst_cause_capture #(.HOLD_CYC(HOLD)) dut (
      .clk(clk), .rst_n(rst_n), .req_i(req_i), .rd_en_i(rd_en_i),
      .rd_data_o(rd_data_o), .rd_level_o(rd_level_o), .dom_rst_o(dom_rst_o)
   );

   function automatic void chk(string tag, int act, int exp);
      n_chk++;
      if (act != exp) begin
         n_bad++;
         $display("FAIL %s: actual=0x%0h expected=0x%0h", tag, act, exp);
      end
   endfunction

   // monitor: one expected domain vector per cycle
   initial begin
      forever begin
         @(negedge clk);
         #1;
         if (exp_q.size() != 0) begin
            exp_t e;
            e = exp_q.pop_front();
            chk(e.tag, int'(dom_rst_o), int'(e.mask));
         end
      end
   end

   function automatic void push(logic [4:0] m, string tag);
      exp_t e;
      e.mask = m;
      e.tag = tag;
      exp_q.push_back(e);
   endfunction

   // R9: hold HOLD+1 cycles, then drop highest bit per cycle
   function automatic void push_seq(logic [4:0] m, string tag);
      logic [4:0] v;
      v = m;
      for (int k = 0; k <= HOLD; k++) push(v, tag);
      while (v != '0) begin
         for (int b = 4; b >= 0; b--) begin
            if (v[b]) begin
               v[b] = 1'b0;
               break;
            end
         end
         push(v, tag);
      end
   endfunction

   task automatic drive_and_expect(logic [31:0] r, logic [4:0] m, string tag);
      @(negedge clk);
      req_i = r;
      @(posedge clk);
      push_seq(m, tag);
      @(negedge clk);
      req_i = '0;
      wait (exp_q.size() == 0);
   endtask

   task automatic do_read(int code, int lvl, string tag);
      @(negedge clk);
      rd_en_i = 1'b1;
      #1;
      chk({tag, " code"}, int'(rd_data_o), code);
      chk({tag, " level"}, int'(rd_level_o), lvl);
      @(negedge clk);
      rd_en_i = 1'b0;
   endtask

   initial begin
      repeat (20000) @(posedge clk);
      n_bad++;
      $display("FAIL R9 watchdog: actual=hung expected=complete");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
   end

   initial begin
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);
      #1;
      chk("R1 reset domains", int'(dom_rst_o), 0);
      do_read(0, 0, "R1 empty read");

      // single watchdog-type cause, boot level
      drive_and_expect(32'h1 << 14, 5'b00111, "R8 R9 code 0x0E domains");
      do_read(14, 3, "R2 R7 read 0x0E");
      do_read(0, 0, "R2 second read");

      // multi-hot: 0x1B, 0x09, 0x15
      drive_and_expect((32'h1 << 27) | (32'h1 << 9) | (32'h1 << 21), 5'b00111, "R3 multi domains");
      do_read(9, 3, "R3 lowest of three");

      drive_and_expect((32'h1 << 2) | (32'h1 << 4), 5'b11111, "R8 por domains");
      do_read(2, 1, "R3 R7 por wins over bor");

      drive_and_expect(32'h1 << 4, 5'b01111, "R8 bor domains");
      do_read(4, 2, "R7 bor level");

      // reserved and bit 0 ignored
      drive_and_expect(32'h1 | (32'h1 << 6) | (32'h1 << 7) | (32'h1 << 18) | (32'h1 << 31),
                       5'b00000, "R4 reserved no domains");
      do_read(0, 0, "R4 reserved not recorded");

      // sticky minimum
      drive_and_expect(32'h1 << 29, 5'b00001, "R8 cpu domains");
      drive_and_expect(32'h1 << 20, 5'b00011, "R8 sys domains");
      do_read(20, 4, "R5 smaller replaces");
      drive_and_expect(32'h1 << 20, 5'b00011, "R8 sys domains again");
      drive_and_expect(32'h1 << 28, 5'b00001, "R8 cpu domains again");
      do_read(20, 4, "R5 larger ignored");
      drive_and_expect(32'h1 << 28, 5'b00001, "R8 cpu only");
      do_read(28, 5, "R7 cpu level");

      // read and capture in the same cycle
      drive_and_expect(32'h1 << 27, 5'b00011, "R8 sys 0x1B");
      @(negedge clk);
      rd_en_i = 1'b1;
      req_i = 32'h1 << 12;
      #1;
      chk("R6 read returns old code", int'(rd_data_o), 27);
      @(negedge clk);
      rd_en_i = 1'b0;
      req_i = '0;
      repeat (HOLD + 10) @(negedge clk);
      do_read(12, 3, "R6 new cause kept");

      // merge during a running sequence
      @(negedge clk);
      req_i = 32'h1 << 28;
      @(posedge clk);
      push(5'b00001, "R10 before merge");
      push(5'b00001, "R10 before merge");
      push_seq(5'b00111, "R10 merged restart");
      @(negedge clk);
      req_i = '0;
      @(negedge clk);
      req_i = 32'h1 << 14;
      @(negedge clk);
      req_i = '0;
      wait (exp_q.size() == 0);
      do_read(14, 3, "R10 R5 merged code");

      repeat (2) @(negedge clk);
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
   end

endmodule